// File: doc/BRIEF.md
# Address-Stability Auto-Sleep Controller

This block sits beside a read array and decides, from the address bus alone, when the array may drop into a low-power sleep state. It counts clock cycles while the address holds still. Once the count passes a programmable access time plus a fixed extra margin, it raises a sleep flag. Before that, at the moment the access time has elapsed, it captures the array's read data into a holding register. That register keeps driving the output for as long as the block sleeps, so data can be read at any time without waking the array.

A new address ends sleep at once and starts a fresh access, with the usual access delay before the new data is captured. An internal program or erase operation, signalled on `busy`, keeps the array awake for as long as it runs. This holds whatever the chip-select state. The select, output-enable and write-enable strobes are accepted as inputs but play no part in sleep entry or exit.

Top module: `asc_sleep_ctrl`

## Requirements
- R1: Let E0 be the rising clock edge at which `addr` first differs from its value at the previous edge. If `addr` then holds and `busy` stays low, `sleep` goes high after edge E0+ACC_CYC+MARGIN_CYC+1 and is low after every earlier edge.
- R2: `sel_n`, `oe_n` and `we_n` have no effect on `sleep`, `dout` or `dvalid` in any combination or sequence.
- R3: While `sleep` is high, `dout` stays constant even when `arr_rdata` changes.
- R4: A changed address clears `sleep` and `dvalid` after edge E0. The new `arr_rdata` is loaded into `dout` at edge E0+ACC_CYC+1, and `dvalid` is high after that edge.
- R5: While `busy` is high, `sleep` and `dvalid` are low after every edge, whatever the enables are. The edge at which `busy` is last high acts as E0 for the timing of R1 and R4.
- R6: `dvalid` rises MARGIN_CYC edges (MARGIN_CYC >= 1) before `sleep` rises, so `sleep` high always implies `dvalid` high.
- R7: The stability counter saturates. Under an address held for any length of time, `sleep` stays high and never drops by wrap-around.
- R8: A clock edge with `rst` high clears `sleep`, `dvalid` and `dout` to 0.
- R9: The last edge with `rst` high acts as E0. An address held through reset release leads to sleep under the timing of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Array address being watched |
| sel_n | input | 1 | Chip select, active low (no effect on sleep) |
| oe_n | input | 1 | Output enable, active low (no effect on sleep) |
| we_n | input | 1 | Write enable, active low (no effect on sleep) |
| busy | input | 1 | Program or erase operation in progress |
| arr_rdata | input | DATA_W | Read data from the array |
| sleep | output | 1 | Array may sleep |
| dout | output | DATA_W | Held read data |
| dvalid | output | 1 | `dout` holds data for the current address |

## Verification
The bench builds the block with ADDR_W=8, DATA_W=16, ACC_CYC=4 and MARGIN_CYC=3. The whole sleep window is therefore eight edges, and a 40-cycle hold drives the counter well into saturation. With these small values, every edge of each access window can be compared against a cycle model. This covers the capture edge, the sleep edge, the cases that fall one edge short of them, and wake-up in the middle of a window. Varying the array data and the enable strobes during sleep shows that the held output does not follow them.

// File: rtl/asc_pkg.sv
package asc_pkg;
  // Width of a counter that must reach lim without wrapping.
  function automatic int cnt_width(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/asc_addr_watch.sv
module asc_addr_watch #(
  parameter int ADDR_W = 22,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              changed
);
  localparam int LANES = (ADDR_W + LANE_W - 1) / LANE_W;
  localparam int PAD_W = LANES * LANE_W;

  logic [PAD_W-1:0] cur_p, old_p;
  logic [LANES-1:0] lane_diff;

  always_ff @(posedge clk) begin
    addr_q <= addr;
  end

  always_comb begin
    cur_p = '0;
    old_p = '0;
    cur_p[ADDR_W-1:0] = addr;
    old_p[ADDR_W-1:0] = addr_q;
  end

  // Compare the bus in lanes, then reduce.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_diff[g] = |(cur_p[g*LANE_W +: LANE_W] ^ old_p[g*LANE_W +: LANE_W]);
  end

  assign changed = |lane_diff;
endmodule

// File: rtl/asc_stab_count.sv
module asc_stab_count #(
  parameter int ACC_CYC = 14,
  parameter int LIMIT   = 26,
  parameter int CW      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [CW-1:0] cnt,
  output logic          at_acc,
  output logic          at_lim
);
  localparam logic [CW-1:0] ACC_V = CW'(ACC_CYC);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (cnt != LIM_V) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign at_acc = (cnt == ACC_V);
  assign at_lim = (cnt == LIM_V);
endmodule

// File: rtl/asc_data_hold.sv
module asc_data_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              load,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      dvalid <= 1'b0;
    end else if (restart) begin
      dvalid <= 1'b0;
    end else if (load) begin
      dout   <= rdata;
      dvalid <= 1'b1;
    end
  end
endmodule

// File: rtl/asc_sleep_ctrl.sv
module asc_sleep_ctrl #(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int ACC_CYC    = 14,
  parameter int MARGIN_CYC = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              busy,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              sleep,
  output logic [DATA_W-1:0] dout,
  output logic              dvalid
);
  localparam int LIMIT = ACC_CYC + MARGIN_CYC;
  localparam int CW    = asc_pkg::cnt_width(LIMIT);

  logic [ADDR_W-1:0] addr_q;
  logic              changed;
  logic              restart;
  logic [CW-1:0]     cnt;
  logic              at_acc;
  logic              at_lim;
  logic              load;
  logic              sleep_q;
  logic              ctl_unused;

  // Bus strobes take no part in the sleep decision.
  assign ctl_unused = sel_n ^ oe_n ^ we_n;

  asc_addr_watch #(.ADDR_W(ADDR_W)) u_watch (
    .clk     (clk),
    .addr    (addr),
    .addr_q  (addr_q),
    .changed (changed)
  );

  assign restart = changed | busy;
  assign load    = ~restart & at_acc;

  asc_stab_count #(.ACC_CYC(ACC_CYC), .LIMIT(LIMIT), .CW(CW)) u_count (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .cnt     (cnt),
    .at_acc  (at_acc),
    .at_lim  (at_lim)
  );

  asc_data_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .load    (load),
    .rdata   (arr_rdata),
    .dout    (dout),
    .dvalid  (dvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q <= 1'b0;
    end else begin
      sleep_q <= ~restart & at_lim;
    end
  end

  assign sleep = sleep_q;
endmodule

// File: rtl/asc_sleep_ctrl_chk.sv
module asc_sleep_ctrl_chk #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int LIMIT  = 26,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] addr_q,
  input logic              busy,
  input logic [CW-1:0]     cnt,
  input logic              sleep,
  input logic [DATA_W-1:0] dout,
  input logic              dvalid
);
  // R4: a seen address change leaves sleep at the next edge
  a_r4_wake_on_change: assert property (@(posedge clk) disable iff (rst)
    (addr != addr_q) |=> !sleep);

  // R5: a busy operation keeps the array awake
  a_r5_busy_awake: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!sleep && !dvalid));

  // R6: data is captured before sleep is allowed
  a_r6_valid_in_sleep: assert property (@(posedge clk) disable iff (rst)
    sleep |-> dvalid);

  // R3: held data is frozen across consecutive sleep cycles
  a_r3_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    (sleep && $past(sleep)) |-> $stable(dout));

  // R1: sleep rises only after the counter reached the full window
  a_r1_rise_at_limit: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep) |-> ($past(cnt) == CW'(LIMIT)));

  // R8: reset clears the flags
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!sleep && !dvalid));
endmodule

bind asc_sleep_ctrl asc_sleep_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LIMIT(LIMIT), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .addr_q(addr_q), .busy(busy),
  .cnt(cnt), .sleep(sleep), .dout(dout), .dvalid(dvalid)
);

// File: tb/asc_sleep_ctrl_bench.sv
module asc_sleep_ctrl_bench;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int ACC    = 4;
  localparam int MARGIN = 3;
  localparam int LIM    = ACC + MARGIN;
  localparam int NV     = 10;

  // entry: {addr[8], hold[8], ctl{sel_n,oe_n,we_n}[3], busy[1], noise[8], tag[4]}
  localparam logic [31:0] VEC [NV] = '{
    {8'h10, 8'd12, 3'b111, 1'b0, 8'h00, 4'd1},
    {8'h10, 8'd6,  3'b010, 1'b0, 8'h00, 4'd2},
    {8'h10, 8'd5,  3'b101, 1'b0, 8'hFF, 4'd3},
    {8'h22, 8'd9,  3'b000, 1'b0, 8'h00, 4'd4},
    {8'h23, 8'd3,  3'b011, 1'b0, 8'h00, 4'd1},
    {8'h24, 8'd10, 3'b111, 1'b1, 8'h00, 4'd5},
    {8'h24, 8'd10, 3'b110, 1'b0, 8'h00, 4'd5},
    {8'h63, 8'd40, 3'b001, 1'b0, 8'h00, 4'd7},
    {8'h62, 8'd5,  3'b000, 1'b0, 8'h3C, 4'd6},
    {8'h62, 8'd6,  3'b100, 1'b0, 8'h00, 4'd6}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              sel_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [7:0]        noise = '0;
  logic [DATA_W-1:0] arr_rdata;
  logic              sleep, dvalid;
  logic [DATA_W-1:0] dout;

  int checks = 0;
  int errors = 0;

  // expected-state model
  int                m = 0;
  logic              e_sleep = 1'b0, e_valid = 1'b0;
  logic [DATA_W-1:0] e_dout = '0;
  logic [ADDR_W-1:0] p_addr = '0;

  always #2.5 clk = ~clk;

  assign arr_rdata = {addr, ~addr} ^ {noise, noise};

  asc_sleep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYC(ACC), .MARGIN_CYC(MARGIN))
    u_asc_sleep_ctrl (
      .clk(clk), .rst(rst), .addr(addr), .sel_n(sel_n), .oe_n(oe_n), .we_n(we_n),
      .busy(busy), .arr_rdata(arr_rdata), .sleep(sleep), .dout(dout), .dvalid(dvalid));

  function automatic string tag_of(input int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3";
      4: return "R4"; 5: return "R5"; 6: return "R6";
      7: return "R7"; 8: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: update model at the edge, compare at the falling edge
  task automatic step(input string tag);
    @(posedge clk);
    if (rst) begin
      m = 0; e_sleep = 1'b0; e_valid = 1'b0; e_dout = '0;
    end else if (addr != p_addr || busy) begin
      m = 0; e_sleep = 1'b0; e_valid = 1'b0;
    end else begin
      e_sleep = (m == LIM);
      if (m == ACC) begin
        e_dout  = arr_rdata;
        e_valid = 1'b1;
      end
      if (m < LIM) m++;
    end
    p_addr = addr;
    @(negedge clk);
    chk(tag, "sleep", 32'(sleep), 32'(e_sleep));
    chk(tag, "dvalid", 32'(dvalid), 32'(e_valid));
    chk(tag, "dout", 32'(dout), 32'(e_dout));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state
    step("R8");
    step("R8");
    rst = 1'b0;

    // R9: address held through reset release sleeps after LIM+1 edges
    for (int i = 0; i < LIM + 3; i++) step("R9");
    chk("R9", "sleep after window", 32'(sleep), 32'd1);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      addr  = VEC[v][31:24];
      {sel_n, oe_n, we_n} = VEC[v][15:13];
      busy  = VEC[v][12];
      noise = VEC[v][11:4];
      for (int c = 0; c < int'(VEC[v][23:16]); c++) step(tag_of(int'(VEC[v][3:0])));
    end

    // R6 / R1: count edges to capture and to sleep after a change
    begin
      int t_valid = -1;
      int t_sleep = -1;
      addr = 8'h5A; noise = 8'h00;
      for (int e = 1; e <= LIM + 4; e++) begin
        step("R6");
        if (dvalid && t_valid < 0) t_valid = e;
        if (sleep && t_sleep < 0) t_sleep = e;
      end
      chk("R6", "capture edge", 32'(t_valid), 32'(ACC + 2));
      chk("R1", "sleep edge", 32'(t_sleep), 32'(LIM + 2));
    end

    // R2: strobes toggled each cycle during sleep
    for (int i = 0; i < 8; i++) begin
      {sel_n, oe_n, we_n} = 3'(i);
      step("R2");
      chk("R2", "still asleep", 32'(sleep), 32'd1);
    end

    // R4: change exactly one edge before sleep would assert
    addr = 8'h5B;
    for (int i = 0; i < LIM + 1; i++) step("R4");
    addr = 8'h5C;
    step("R4");
    chk("R4", "no sleep at window end", 32'(sleep), 32'd0);

    // R8: reset in the middle of sleep
    for (int i = 0; i < LIM + 2; i++) step("R1");
    rst = 1'b1;
    step("R8");
    chk("R8", "dout cleared", 32'(dout), 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) step("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule